// File: doc/BRIEF.md
# Pulse-Swallow Channel Divider

This block is the digital division chain of a PLL frequency synthesizer. On the feedback side it divides the oscillator-rate input clock by `P*N + A`. A dual-modulus prescaler (P or P+1) feeds a fixed main counter of N periods. A swallow counter holds the prescaler at P+1 for the first A main periods of every feedback cycle. With the defaults (P = 32, N = 47), channels 1 to 41 give a total division of 1505 to 1545 input cycles. On the reference side, a fixed divider emits one pulse for every R = 16 enabled reference ticks. Both results are single-cycle pulses, meant for a phase detector outside the block.

The channel number is loaded through a three-wire serial port with a serial clock, a data line and a latch enable. These lines are sampled in the `clk` domain and must be held for at least one `clk` cycle per level. A rising edge of latch enable moves the 6-bit shift register into a pending channel register, provided the word is a legal channel. The divider picks up the pending channel only when a new feedback cycle begins, so no feedback cycle ever mixes two division ratios.

Top module: `pswallow_divider`

## Requirements
- R1: A synchronous active-high reset clears all counters, selects channel 1 and holds `fb_pulse`, `ref_pulse` and `chan_err` low. The first feedback period after reset is 1505 cycles.
- R2: The feedback period between two `fb_pulse` assertions is exactly 32*47 + A input clock cycles for the active channel A. To produce this, the prescaler divides by 33 for the first A main-counter periods of each cycle and by 32 for the remaining 47 - A periods.
- R3: `fb_pulse` is high for exactly one input clock cycle per feedback period.
- R4: When `ref_ce` is high every cycle, `ref_pulse` repeats every 16 cycles. Only cycles with `ref_ce` high advance the reference divider, and each `ref_pulse` is one cycle wide.
- R5: Each rising edge of `ser_clk` shifts `ser_data` into the 6-bit register. The first bit sent ends up as the MSB (bit 5) of the channel word.
- R6: A rising edge of `ser_le` with a word from 1 to 41 makes that word the pending channel, and `chan_err` stays low.
- R7: A channel latched in the middle of a feedback cycle does not change that cycle. It sets the length of the next cycle.
- R8: A latched word of 0 or of 42 to 63 is rejected and the previous channel stays in use. `chan_err` is high for exactly the one cycle that follows the `clk` edge at which the latch-enable rise is seen.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator-rate input clock; all logic is clocked on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ref_ce | input | 1 | Reference tick; each high cycle advances the reference divider |
| ser_clk | input | 1 | Serial shift clock (sampled) |
| ser_data | input | 1 | Serial data, first bit sent is the MSB |
| ser_le | input | 1 | Latch enable; rising edge transfers the shift register |
| fb_pulse | output | 1 | One-cycle pulse at the end of each feedback cycle |
| ref_pulse | output | 1 | One-cycle pulse every R enabled reference ticks |
| chan_err | output | 1 | One-cycle flag for a rejected channel word |

## Verification
The bench builds the block with its default parameters: prescaler 32/33, main count 47, swallow range 1 to 41, reference ratio 16. At these values a feedback period is only about 1.5k cycles, so every legal channel can be programmed in turn and its period measured from edge to edge. The illegal words 0, 42 and 63 are also tried. A bit-reversed word pair shows the shift order, and a latch placed in the middle of a cycle shows when a new channel takes effect. The reference path is measured both with a continuous tick and with a tick on every second cycle.

// File: rtl/psw_pkg.sv
package psw_pkg;

    localparam int unsigned PRESC_BASE = 32;
    localparam int unsigned MAIN_COUNT = 47;
    localparam int unsigned SWALLOW_MAX = 41;
    localparam int unsigned REF_RATIO = 16;
    localparam int unsigned CHAN_BITS = 6;

    typedef enum logic {
        MOD_BASE = 1'b0,
        MOD_PLUS = 1'b1
    } mod_e;

    typedef struct packed {
        logic accept;
        logic reject;
    } latch_res_t;

    function automatic latch_res_t judge_word(input int unsigned word, input int unsigned max_ch);
        latch_res_t r;
        r.accept = (word >= 1) && (word <= max_ch);
        r.reject = !r.accept;
        return r;
    endfunction

endpackage

// File: rtl/psw_prescaler.sv
module psw_prescaler
    import psw_pkg::*;
#(
    parameter int unsigned P = PRESC_BASE
) (
    input  logic clk,
    input  logic rst,
    input  mod_e mod_sel,
    output logic tc
);
    localparam int unsigned CW = $clog2(P + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] last;

    assign last = (mod_sel == MOD_PLUS) ? CW'(P) : CW'(P - 1);
    assign tc   = (cnt == last);

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (tc)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    assert_presc_bound_R2: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(P));

    assert_presc_wrap_R2: assert property (@(posedge clk) disable iff (rst)
        tc |=> (cnt == '0));

endmodule

// File: rtl/psw_chain.sv
module psw_chain
    import psw_pkg::*;
#(
    parameter int unsigned N  = MAIN_COUNT,
    parameter int unsigned AMAX = SWALLOW_MAX,
    parameter int unsigned AW = CHAN_BITS
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          pre_tc,
    input  logic [AW-1:0] chan_pend,
    output mod_e          mod_sel,
    output logic          fb_pulse
);
    localparam int unsigned NW = $clog2(N);

    logic [NW-1:0] main_cnt;
    logic [AW-1:0] swal_cnt;
    logic [AW-1:0] div_a;

    assign mod_sel  = (swal_cnt < div_a) ? MOD_PLUS : MOD_BASE;
    assign fb_pulse = pre_tc && (main_cnt == NW'(N - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            main_cnt <= '0;
            swal_cnt <= '0;
            div_a    <= AW'(1);
        end else if (fb_pulse) begin
            main_cnt <= '0;
            swal_cnt <= '0;
            div_a    <= chan_pend;
        end else if (pre_tc) begin
            main_cnt <= main_cnt + 1'b1;
            if (mod_sel == MOD_PLUS)
                swal_cnt <= swal_cnt + 1'b1;
        end
    end

    assert_swallow_window_R2: assert property (@(posedge clk) disable iff (rst)
        (mod_sel == MOD_PLUS) |-> (AW'(main_cnt) < div_a));

    assert_mod_changes_on_tc_R2: assert property (@(posedge clk) disable iff (rst)
        !pre_tc |=> $stable(mod_sel));

    assert_fb_single_R3: assert property (@(posedge clk) disable iff (rst)
        fb_pulse |=> !fb_pulse);

    assert_chan_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !fb_pulse |=> $stable(div_a));

    assert_chan_range_R8: assert property (@(posedge clk) disable iff (rst)
        (div_a >= AW'(1)) && (div_a <= AW'(AMAX)));

endmodule

// File: rtl/psw_refdiv.sv
module psw_refdiv
    import psw_pkg::*;
#(
    parameter int unsigned R = REF_RATIO
) (
    input  logic clk,
    input  logic rst,
    input  logic ce,
    output logic pulse
);
    localparam int unsigned RW = (R > 1) ? $clog2(R) : 1;

    logic [RW-1:0] cnt;

    assign pulse = ce && (cnt == RW'(R - 1));

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (pulse)
            cnt <= '0;
        else if (ce)
            cnt <= cnt + 1'b1;
    end

    assert_ref_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !ce |=> $stable(cnt));

    assert_ref_single_R4: assert property (@(posedge clk) disable iff (rst)
        pulse |=> !pulse);

endmodule

// File: rtl/psw_serial.sv
module psw_serial
    import psw_pkg::*;
#(
    parameter int unsigned AW   = CHAN_BITS,
    parameter int unsigned AMAX = SWALLOW_MAX
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ser_clk,
    input  logic          ser_data,
    input  logic          ser_le,
    output logic [AW-1:0] chan_pend,
    output logic          chan_err
);
    logic          sclk_q;
    logic          le_q;
    logic [AW-1:0] shreg;
    logic          shift_en;
    logic          latch_en;
    latch_res_t    verdict;

    assign shift_en = ser_clk && !sclk_q;
    assign latch_en = ser_le && !le_q;
    assign verdict  = judge_word(int'(shreg), AMAX);

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q    <= 1'b0;
            le_q      <= 1'b0;
            shreg     <= '0;
            chan_pend <= AW'(1);
            chan_err  <= 1'b0;
        end else begin
            sclk_q   <= ser_clk;
            le_q     <= ser_le;
            chan_err <= latch_en && verdict.reject;
            if (shift_en)
                shreg <= {shreg[AW-2:0], ser_data};
            if (latch_en && verdict.accept)
                chan_pend <= shreg;
        end
    end

    assert_err_single_R8: assert property (@(posedge clk) disable iff (rst)
        chan_err |=> !chan_err);

    assert_err_keeps_chan_R8: assert property (@(posedge clk) disable iff (rst)
        chan_err |-> $stable(chan_pend));

    assert_pend_range_R6: assert property (@(posedge clk) disable iff (rst)
        (chan_pend >= AW'(1)) && (chan_pend <= AW'(AMAX)));

endmodule

// File: rtl/pswallow_divider.sv
module pswallow_divider
    import psw_pkg::*;
#(
    parameter int unsigned P    = PRESC_BASE,
    parameter int unsigned N    = MAIN_COUNT,
    parameter int unsigned AMAX = SWALLOW_MAX,
    parameter int unsigned R    = REF_RATIO,
    parameter int unsigned AW   = CHAN_BITS
) (
    input  logic clk,
    input  logic rst,
    input  logic ref_ce,
    input  logic ser_clk,
    input  logic ser_data,
    input  logic ser_le,
    output logic fb_pulse,
    output logic ref_pulse,
    output logic chan_err
);
    logic          pre_tc;
    mod_e          mod_sel;
    logic [AW-1:0] chan_pend;

    psw_serial #(.AW(AW), .AMAX(AMAX)) u_serial (
        .clk       (clk),
        .rst       (rst),
        .ser_clk   (ser_clk),
        .ser_data  (ser_data),
        .ser_le    (ser_le),
        .chan_pend (chan_pend),
        .chan_err  (chan_err)
    );

    psw_prescaler #(.P(P)) u_presc (
        .clk     (clk),
        .rst     (rst),
        .mod_sel (mod_sel),
        .tc      (pre_tc)
    );

    psw_chain #(.N(N), .AMAX(AMAX), .AW(AW)) u_chain (
        .clk       (clk),
        .rst       (rst),
        .pre_tc    (pre_tc),
        .chan_pend (chan_pend),
        .mod_sel   (mod_sel),
        .fb_pulse  (fb_pulse)
    );

    psw_refdiv #(.R(R)) u_ref (
        .clk   (clk),
        .rst   (rst),
        .ce    (ref_ce),
        .pulse (ref_pulse)
    );

    initial begin
        assert_swallow_legal_R2: assert (AMAX < N);
    end

endmodule

// File: tb/pswallow_divider_test.sv
`timescale 1ns/1ps
module pswallow_divider_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ref_ce = 1'b1;
    logic ser_clk = 1'b0;
    logic ser_data = 1'b0;
    logic ser_le = 1'b0;
    logic fb_pulse, ref_pulse, chan_err;
    logic ref_toggle = 1'b0;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    int fb_last = 0, fb_per = 0, fb_cnt = 0;
    int ref_last = 0, ref_per = 0, ref_cnt = 0;
    bit fb_prev = 0, ref_prev = 0;
    int fb_wide = 0, ref_wide = 0;

    pswallow_divider uut (
        .clk(clk), .rst(rst), .ref_ce(ref_ce), .ser_clk(ser_clk),
        .ser_data(ser_data), .ser_le(ser_le), .fb_pulse(fb_pulse),
        .ref_pulse(ref_pulse), .chan_err(chan_err)
    );

    always #2 clk = ~clk;

    always @(negedge clk) begin
        ref_ce <= ref_toggle ? ~ref_ce : 1'b1;
    end

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (!rst) begin
            if (fb_pulse) begin
                if (fb_prev) fb_wide = fb_wide + 1;
                else begin
                    if (fb_cnt > 0) fb_per = cyc - fb_last;
                    fb_last = cyc;
                    fb_cnt = fb_cnt + 1;
                end
            end
            if (ref_pulse) begin
                if (ref_prev) ref_wide = ref_wide + 1;
                else begin
                    if (ref_cnt > 0) ref_per = cyc - ref_last;
                    ref_last = cyc;
                    ref_cnt = ref_cnt + 1;
                end
            end
        end
        fb_prev = fb_pulse;
        ref_prev = ref_pulse;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_fb();
        int n = fb_cnt;
        while (fb_cnt == n) @(negedge clk);
    endtask

    task automatic wait_ref();
        int n = ref_cnt;
        while (ref_cnt == n) @(negedge clk);
    endtask

    task automatic send(input logic [5:0] w, input bit exp_err, input string req);
        for (int i = 5; i >= 0; i--) begin
            @(negedge clk); ser_data = w[i]; ser_clk = 1'b0;
            @(negedge clk);
            @(negedge clk); ser_clk = 1'b1;
            @(negedge clk);
        end
        @(negedge clk); ser_clk = 1'b0; ser_le = 1'b1;
        @(negedge clk);
        check(chan_err == exp_err, req, chan_err, exp_err);
        @(negedge clk);
        check(chan_err == 1'b0, req, chan_err, 0);
        ser_le = 1'b0;
    endtask

    function automatic int period(input int ch);
        return 32 * 47 + ch;
    endfunction

    task automatic run_all();
        repeat (4) @(negedge clk);
        check(fb_pulse == 0 && ref_pulse == 0 && chan_err == 0, "R1 reset outputs", fb_pulse, 0);
        rst = 1'b0;
        wait_fb();
        wait_fb();
        check(fb_per == period(1), "R1 first period", fb_per, period(1));

        wait_ref(); wait_ref();
        check(ref_per == 16, "R4 ref period", ref_per, 16);
        ref_toggle = 1'b1;
        wait_ref(); wait_ref(); wait_ref();
        check(ref_per == 32, "R4 ref half rate", ref_per, 32);
        ref_toggle = 1'b0;
        wait_ref(); wait_ref(); wait_ref();
        check(ref_per == 16, "R4 ref restored", ref_per, 16);

        for (int ch = 1; ch <= 41; ch++) begin
            send(6'(ch), 1'b0, "R6 legal word");
            wait_fb();
            wait_fb();
            check(fb_per == period(ch), "R2 channel period", fb_per, period(ch));
        end

        send(6'b000110, 1'b0, "R5 word 6");
        wait_fb(); wait_fb();
        check(fb_per == period(6), "R5 msb first 6", fb_per, period(6));
        send(6'b011000, 1'b0, "R5 word 24");
        wait_fb(); wait_fb();
        check(fb_per == period(24), "R5 msb first 24", fb_per, period(24));

        wait_fb();
        repeat (300) @(negedge clk);
        send(6'd40, 1'b0, "R7 mid latch");
        wait_fb();
        check(fb_per == period(24), "R7 current cycle unchanged", fb_per, period(24));
        wait_fb();
        check(fb_per == period(40), "R7 next cycle new", fb_per, period(40));

        send(6'd0, 1'b1, "R8 zero flagged");
        wait_fb(); wait_fb();
        check(fb_per == period(40), "R8 zero rejected", fb_per, period(40));
        send(6'd42, 1'b1, "R8 42 flagged");
        wait_fb(); wait_fb();
        check(fb_per == period(40), "R8 42 rejected", fb_per, period(40));
        send(6'd63, 1'b1, "R8 63 flagged");
        wait_fb(); wait_fb();
        check(fb_per == period(40), "R8 63 rejected", fb_per, period(40));

        check(fb_wide == 0, "R3 fb width", fb_wide, 0);
        check(ref_wide == 0, "R4 ref width", ref_wide, 0);
    endtask

    initial begin
        fork
            run_all();
            begin
                #(4 * 195000);
                n_chk++; n_bad++;
                $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            end
        join_any
        disable fork;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule